// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a computer-operating-properly watchdog. Software must service it by writing two key bytes to a service port in a fixed order. If it does not do so before the timeout, a single-cycle reset request goes to the chip's reset generator. A write of any other byte also raises the request at once. So does a key pair that completes too early while the window option is on. A sticky cause flag records that the watchdog made the request. This flag survives the system reset that follows and is cleared only by a power-on reset.

The timebase is either an external slow tick of about 1 kHz (a one-cycle enable pulse) or the bus clock divided by a fixed power-of-two prescaler. A two-bit timeout select picks the period or turns the watchdog off. Configuration can be accepted once per system reset. Until that write arrives, the block runs with the longest timeout on the slow tick, in normal (unwindowed) mode. Debug and stop modes freeze the timer. With the slow tick selected, the counter is also forced to zero while frozen.

Top module: `keyed_watchdog`

## Requirements
- R1: After system reset, `rstReq` is 0 and the watchdog is active with timeout select 3, the slow tick and no window, so it requests a reset after 1024 ticks if never serviced.
- R2: A write of 0x55 followed by a write of 0xAA to the service port clears the counter to zero, so a full timeout period is needed before the next request.
- R3: Timeout select 1, 2 and 3 give 32, 256 and 1024 timebase ticks. `rstReq` rises on the cycle after the clock edge that samples the final tick.
- R4: While the watchdog is enabled, a service write of any byte other than 0x55 or 0xAA raises `rstReq` on the next cycle.
- R5: A write of 0xAA that does not directly follow an armed 0x55 is a violation and raises `rstReq`. Repeated 0x55 writes leave the checker armed, so a following 0xAA is still a valid service.
- R6: With the window enabled (`cfgWindowEn` = 1), a key pair that completes while the counter is below 3/4 of the terminal count raises `rstReq`. A pair that completes at or above that point is a clean service.
- R7: With the slow tick selected, the counter is held at zero while `debugMode` or `stopMode` is high, and ticks during that time are ignored. Counting restarts from zero on exit.
- R8: With `cfgBusClk` = 1, one timebase tick occurs every 2^BUS_PRE_LOG2 bus cycles. While `debugMode` or `stopMode` is high, both the prescaler and the counter hold their values.
- R9: `copCause` is set together with every reset request. It stays set through `rstN` and clears only when `porN` is low.
- R10: The first configuration write after `rstN` is accepted and restarts the count. Every later configuration write is ignored.
- R11: `rstReq` is high for exactly one cycle per triggering event.
- R12: Timeout select 0 disables the watchdog. Ticks and service writes of any value then raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low system reset; clears timer, key checker, config and lock |
| porN | input | 1 | Active-low power-on reset; also clears the cause flag |
| lpTick | input | 1 | One-cycle pulse from the slow (about 1 kHz) timebase |
| cfgWrEn | input | 1 | Configuration write strobe (accepted once) |
| cfgTmoSel | input | 2 | Timeout select: 0 off, 1 = 2^5, 2 = 2^8, 3 = 2^10 ticks |
| cfgBusClk | input | 1 | 1 = prescaled bus clock timebase, 0 = slow tick |
| cfgWindowEn | input | 1 | 1 = windowed service mode |
| svcWrEn | input | 1 | Service port write strobe |
| svcData | input | 8 | Byte written to the service port |
| debugMode | input | 1 | Processor halted in debug |
| stopMode | input | 1 | Chip in stop mode |
| rstReq | output | 1 | Single-cycle reset request to the reset generator |
| copCause | output | 1 | Sticky flag: last reset was requested by the watchdog |

## Verification
The embedded assertions check the following relations on every cycle: the counter never reaches the terminal count, a bad byte or an unarmed 0xAA always produces a request, and an early pair in windowed mode always produces one. They also check that debug or stop zeroes the counter on the slow tick and holds it on the bus clock, that a locked configuration stays unchanged, that the cause flag is sticky, and that a disabled watchdog stays quiet. Other properties only the directed scenarios can show. These include the exact tick on which each timeout fires, the 3/4 window boundary at its 23rd and 24th tick, and whether a service really restarts a full period. They also include the single-cycle width of the request and the way the cause flag outlives a system reset but not a power-on reset.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  typedef struct packed {
    logic [1:0] tmoSel;
    logic       busClk;
    logic       windowEn;
  } kwdCfg_t;

  typedef struct packed {
    logic runEn;
    logic clrCount;
  } kwdStrobe_t;

  localparam kwdCfg_t CFG_AFTER_RESET = '{tmoSel: 2'd3, busClk: 1'b0, windowEn: 1'b0};
endpackage

// File: rtl/kwd_datapath.sv
module kwd_datapath
  import kwd_pkg::*;
#(
  parameter int T1_LOG2      = 5,
  parameter int T2_LOG2      = 8,
  parameter int T3_LOG2      = 10,
  parameter int BUS_PRE_LOG2 = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lpTick,
  input  logic       debugMode,
  input  logic       stopMode,
  input  logic [1:0] tmoSel,
  input  logic       busClk,
  input  kwdStrobe_t strb,
  output logic       expire,
  output logic       windowOpen
);
  localparam int CNT_W = T3_LOG2 + 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] termCount;
  logic             frozen;
  logic             busTick;
  logic             tickEn;

  always_comb begin
    case (tmoSel)
      2'd2:    termCount = ONE << T2_LOG2;
      2'd3:    termCount = ONE << T3_LOG2;
      default: termCount = ONE << T1_LOG2;
    endcase
  end

  assign frozen = debugMode | stopMode;

  generate
    if (BUS_PRE_LOG2 == 0) begin : g_noPre
      assign busTick = 1'b1;
    end else begin : g_pre
      logic [BUS_PRE_LOG2-1:0] preCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          preCnt <= '0;
        else if (strb.clrCount || !strb.runEn || !busClk)
          preCnt <= '0;
        else if (!frozen)
          preCnt <= preCnt + 1'b1;
      end
      assign busTick = &preCnt;
    end
  endgenerate

  assign tickEn     = busClk ? busTick : lpTick;
  assign expire     = strb.runEn && !frozen && tickEn && (count >= termCount - ONE);
  assign windowOpen = count >= (termCount - (termCount >> 2));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      count <= '0;
    else if (!strb.runEn || strb.clrCount || (frozen && !busClk))
      count <= '0;
    else if (!frozen && tickEn)
      count <= count + ONE;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.runEn |-> (count < termCount)); // R3
  AST_LP_FREEZE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.runEn && !busClk && frozen) |=> (count == '0)); // R7
  AST_BUS_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.runEn && busClk && frozen && !strb.clrCount) |=> $stable(count)); // R8
endmodule

// File: rtl/kwd_ctrl.sv
module kwd_ctrl
  import kwd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       porN,
  input  logic       cfgWrEn,
  input  kwdCfg_t    cfgIn,
  input  logic       svcWrEn,
  input  logic [7:0] svcData,
  input  logic       expire,
  input  logic       windowOpen,
  output kwdCfg_t    cfg,
  output kwdStrobe_t strb,
  output logic       rstReq,
  output logic       causeFlag
);
  logic locked;
  logic armed;
  logic runEn;
  logic cfgAccept;
  logic isArm;
  logic isFire;
  logic badWrite;
  logic early;
  logic fault;
  logic goodSvc;

  assign runEn     = cfg.tmoSel != 2'd0;
  assign cfgAccept = cfgWrEn && !locked;
  assign isArm     = svcWrEn && (svcData == KEY_ARM);
  assign isFire    = svcWrEn && (svcData == KEY_FIRE) && armed;
  assign badWrite  = svcWrEn && !isArm && !isFire;
  assign early     = isFire && cfg.windowEn && !windowOpen;
  assign fault     = runEn && (expire || badWrite || early);
  assign goodSvc   = runEn && isFire && !early;

  assign strb.runEn    = runEn;
  assign strb.clrCount = fault || goodSvc || cfgAccept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg    <= CFG_AFTER_RESET;
      locked <= 1'b0;
    end else if (cfgAccept) begin
      cfg    <= cfgIn;
      locked <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      armed <= 1'b0;
    else if (!runEn || fault || isFire)
      armed <= 1'b0;
    else if (isArm)
      armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rstReq <= 1'b0;
    else
      rstReq <= fault;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)
      causeFlag <= 1'b0;
    else if (fault)
      causeFlag <= 1'b1;
  end

  AST_BAD_KEY_FIRES: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && svcWrEn && svcData != KEY_ARM && svcData != KEY_FIRE) |=> rstReq); // R4
  AST_UNARMED_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && svcWrEn && svcData == KEY_FIRE && !armed) |=> rstReq); // R5
  AST_EARLY_SERVICE: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && cfg.windowEn && isFire && !windowOpen) |=> rstReq); // R6
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (locked && cfgWrEn) |=> $stable(cfg)); // R10
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!porN)
    causeFlag |=> causeFlag); // R9
  AST_CAUSE_WITH_REQ: assert property (@(posedge clk) disable iff (!porN)
    rstReq |-> causeFlag); // R9
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !rstReq); // R12
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int T1_LOG2      = 5,
  parameter int T2_LOG2      = 8,
  parameter int T3_LOG2      = 10,
  parameter int BUS_PRE_LOG2 = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       porN,
  input  logic       lpTick,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgTmoSel,
  input  logic       cfgBusClk,
  input  logic       cfgWindowEn,
  input  logic       svcWrEn,
  input  logic [7:0] svcData,
  input  logic       debugMode,
  input  logic       stopMode,
  output logic       rstReq,
  output logic       copCause
);
  kwdCfg_t    cfgIn;
  kwdCfg_t    cfg;
  kwdStrobe_t strb;
  logic       expire;
  logic       windowOpen;

  assign cfgIn = '{tmoSel: cfgTmoSel, busClk: cfgBusClk, windowEn: cfgWindowEn};

  kwd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .porN(porN),
    .cfgWrEn(cfgWrEn), .cfgIn(cfgIn),
    .svcWrEn(svcWrEn), .svcData(svcData),
    .expire(expire), .windowOpen(windowOpen),
    .cfg(cfg), .strb(strb), .rstReq(rstReq), .causeFlag(copCause)
  );

  kwd_datapath #(
    .T1_LOG2(T1_LOG2), .T2_LOG2(T2_LOG2), .T3_LOG2(T3_LOG2),
    .BUS_PRE_LOG2(BUS_PRE_LOG2)
  ) dp_i (
    .clk(clk), .rstN(rstN), .lpTick(lpTick),
    .debugMode(debugMode), .stopMode(stopMode),
    .tmoSel(cfg.tmoSel), .busClk(cfg.busClk),
    .strb(strb), .expire(expire), .windowOpen(windowOpen)
  );
endmodule

// File: tb/keyed_watchdog_tb_top.sv
module keyed_watchdog_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       porN = 1'b0;
  logic       lpTick = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [1:0] cfgTmoSel = 2'd0;
  logic       cfgBusClk = 1'b0;
  logic       cfgWindowEn = 1'b0;
  logic       svcWrEn = 1'b0;
  logic [7:0] svcData = 8'h00;
  logic       debugMode = 1'b0;
  logic       stopMode = 1'b0;
  logic       rstReq;
  logic       copCause;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  keyed_watchdog #(.BUS_PRE_LOG2(2)) dut_i (
    .clk(clk), .rstN(rstN), .porN(porN), .lpTick(lpTick),
    .cfgWrEn(cfgWrEn), .cfgTmoSel(cfgTmoSel), .cfgBusClk(cfgBusClk),
    .cfgWindowEn(cfgWindowEn), .svcWrEn(svcWrEn), .svcData(svcData),
    .debugMode(debugMode), .stopMode(stopMode),
    .rstReq(rstReq), .copCause(copCause)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nFails = nFails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks = nChecks + 1;
    if (act != exp) begin
      nFails = nFails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sysReset(input logic withPor);
    @(negedge clk);
    rstN = 1'b0;
    if (withPor) porN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    porN = 1'b1;
    @(negedge clk);
  endtask

  task automatic tickOnce(output logic req);
    @(negedge clk);
    lpTick = 1'b1;
    @(negedge clk);
    lpTick = 1'b0;
    req = rstReq;
  endtask

  task automatic ticksQuiet(input int n, input string req);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      logic r;
      tickOnce(r);
      if (r) hits++;
    end
    chk(req, hits, 0);
  endtask

  task automatic idleQuiet(input int n, input string req);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rstReq) hits++;
    end
    chk(req, hits, 0);
  endtask

  task automatic svcWrite(input logic [7:0] b, output logic req);
    @(negedge clk);
    svcWrEn = 1'b1;
    svcData = b;
    @(negedge clk);
    svcWrEn = 1'b0;
    req = rstReq;
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic bus, input logic win);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgTmoSel = sel; cfgBusClk = bus; cfgWindowEn = win;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic testResetDefault;
    logic r;
    sysReset(1'b1);
    chk("R1 rstReq after reset", int'(rstReq), 0);
    chk("R9 cause after power-on", int'(copCause), 0);
    ticksQuiet(1023, "R1 default quiet before 1024");
    tickOnce(r);
    chk("R1 default timeout at tick 1024", int'(r), 1);
    @(negedge clk);
    chk("R11 request one cycle wide", int'(rstReq), 0);
    chk("R9 cause set", int'(copCause), 1);
  endtask

  task automatic testService;
    logic r;
    sysReset(1'b0);
    chk("R9 cause survives rstN", int'(copCause), 1);
    ticksQuiet(1000, "R2 pre-service quiet");
    svcWrite(8'h55, r); chk("R2 arm write", int'(r), 0);
    svcWrite(8'hAA, r); chk("R2 fire write", int'(r), 0);
    ticksQuiet(1023, "R2 full period after service");
    tickOnce(r);
    chk("R2 timeout after restart", int'(r), 1);
    sysReset(1'b1);
    chk("R9 cause cleared by porN", int'(copCause), 0);
  endtask

  task automatic testBadWrite;
    logic r;
    sysReset(1'b0);
    svcWrite(8'h12, r); chk("R4 byte 0x12", int'(r), 1);
    @(negedge clk); chk("R11 bad write pulse width", int'(rstReq), 0);
    svcWrite(8'hA5, r); chk("R4 byte 0xA5", int'(r), 1);
  endtask

  task automatic testKeyOrder;
    logic r;
    sysReset(1'b0);
    svcWrite(8'hAA, r); chk("R5 unarmed 0xAA", int'(r), 1);
    sysReset(1'b0);
    cfgWrite(2'd1, 1'b0, 1'b0);
    ticksQuiet(20, "R5 pre-service");
    svcWrite(8'h55, r); chk("R5 first 0x55", int'(r), 0);
    svcWrite(8'h55, r); chk("R5 repeated 0x55", int'(r), 0);
    svcWrite(8'hAA, r); chk("R5 0xAA after repeat", int'(r), 0);
    ticksQuiet(31, "R5 counter cleared by pair");
    tickOnce(r); chk("R5 timeout after pair", int'(r), 1);
  endtask

  task automatic testTimeoutSel;
    logic r;
    sysReset(1'b0);
    cfgWrite(2'd2, 1'b0, 1'b0);
    ticksQuiet(255, "R3 select 2 quiet");
    tickOnce(r); chk("R3 select 2 at tick 256", int'(r), 1);
  endtask

  task automatic testCfgLock;
    logic r;
    sysReset(1'b0);
    cfgWrite(2'd1, 1'b0, 1'b0);
    ticksQuiet(31, "R10 first config select 1");
    tickOnce(r); chk("R3 select 1 at tick 32", int'(r), 1);
    cfgWrite(2'd0, 1'b0, 1'b0);
    ticksQuiet(31, "R10 disable write ignored");
    tickOnce(r); chk("R10 still select 1", int'(r), 1);
  endtask

  task automatic testWindow;
    logic r;
    sysReset(1'b0);
    cfgWrite(2'd1, 1'b0, 1'b1);
    ticksQuiet(23, "R6 ticks before early pair");
    svcWrite(8'h55, r); chk("R6 arm in early zone", int'(r), 0);
    svcWrite(8'hAA, r); chk("R6 pair at count 23", int'(r), 1);
    ticksQuiet(24, "R6 ticks into window");
    svcWrite(8'h55, r); chk("R6 arm in window", int'(r), 0);
    svcWrite(8'hAA, r); chk("R6 pair at count 24", int'(r), 0);
    ticksQuiet(31, "R6 period after window service");
    tickOnce(r); chk("R6 timeout after window service", int'(r), 1);
  endtask

  task automatic testLpFreeze;
    logic r;
    sysReset(1'b0);
    cfgWrite(2'd1, 1'b0, 1'b0);
    ticksQuiet(20, "R7 before debug");
    debugMode = 1'b1;
    ticksQuiet(5, "R7 ticks in debug");
    debugMode = 1'b0;
    ticksQuiet(31, "R7 restart from zero after debug");
    tickOnce(r); chk("R7 timeout after debug", int'(r), 1);
    ticksQuiet(20, "R7 before stop");
    stopMode = 1'b1;
    ticksQuiet(5, "R7 ticks in stop");
    stopMode = 1'b0;
    ticksQuiet(31, "R7 restart from zero after stop");
    tickOnce(r); chk("R7 timeout after stop", int'(r), 1);
  endtask

  task automatic testBusClock;
    sysReset(1'b0);
    cfgWrite(2'd1, 1'b1, 1'b0);
    idleQuiet(127, "R8 bus period quiet");
    @(negedge clk); chk("R8 bus timeout at cycle 128", int'(rstReq), 1);
    idleQuiet(60, "R8 before debug");
    debugMode = 1'b1;
    idleQuiet(50, "R8 held in debug");
    debugMode = 1'b0;
    idleQuiet(67, "R8 remainder after debug");
    @(negedge clk); chk("R8 timeout delayed by freeze", int'(rstReq), 1);
  endtask

  task automatic testDisabled;
    logic r;
    sysReset(1'b0);
    cfgWrite(2'd0, 1'b0, 1'b0);
    ticksQuiet(100, "R12 disabled ticks");
    svcWrite(8'h12, r); chk("R12 bad byte when disabled", int'(r), 0);
    svcWrite(8'hAA, r); chk("R12 unarmed 0xAA when disabled", int'(r), 0);
  endtask

  initial begin
    testResetDefault();
    testService();
    testBadWrite();
    testKeyOrder();
    testTimeoutSel();
    testCfgLock();
    testWindow();
    testLpFreeze();
    testBusClock();
    testDisabled();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule